// File: doc/BRIEF.md
# Single-Digit BCD Adder

This block adds two binary-coded-decimal digits and an incoming carry in one combinational pass. It returns one decimal result digit and a decimal carry. Internally it first takes the plain binary sum of the operands and the carry-in, giving a 4-bit intermediate digit and a binary carry. It then decides whether that result has left the decimal range. If so, it adds six to the intermediate digit, which brings the digit back into 0..9 and produces the decimal carry.

The correction stage always performs an addition. An adjust term chooses whether the second operand is zero or six. The decimal carry is the OR of the binary carry and the carry out of the correction addition. The carry-in lets a wider design place several of these digits in a row, but that chaining is not part of this block. There are no registers and no reset.

Top module: `bcd_digit_adder`

## Requirements
- R1: When a_digit + b_digit + carry_in is at most 9, sum_digit equals that total and carry_out is 0. This includes all-zero inputs, which give sum_digit 0000 and carry_out 0.
- R2: When the total is 10 to 15, so the binary addition does not carry, sum_digit equals total - 10 and carry_out is 1.
- R3: When the total is 16 or more, so the binary addition carries, carry_out is 1. For digit operands (both at most 9), sum_digit equals total - 10.
- R4: 0010 + 0110 with carry_in 0 gives sum_digit 1000 and carry_out 0.
- R5: 1000 + 1001 with carry_in 0 gives sum_digit 0111 and carry_out 1.
- R6: 0110 + 0101 with carry_in 0 gives sum_digit 0001 and carry_out 1.
- R7: carry_in set to 1 adds exactly one to the total. For digit operands, carry_out * 10 + sum_digit equals a_digit + b_digit + carry_in over all 200 such combinations.
- R8: For any 4-bit operands, including values above 9, the outputs follow from the total T = a_digit + b_digit + carry_in. If T >= 10, sum_digit is (T + 6) mod 16 and carry_out is 1. Otherwise sum_digit is T and carry_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_digit | input | 4 | First operand digit, unsigned binary |
| b_digit | input | 4 | Second operand digit, unsigned binary |
| carry_in | input | 1 | Incoming decimal carry, added into the binary stage |
| sum_digit | output | 4 | Corrected result digit |
| carry_out | output | 1 | Decimal carry |

## Verification
The assertions that tie the result to the decimal total assume both operands are digits no greater than nine. Those assertions stay silent for larger operands. Rules that hold for any input, such as the carry forced by a binary overflow, are checked without that restriction. The stimulus sweeps all 512 combinations of the 4-bit operands and the carry-in. It therefore covers the 200 legal digit cases and also the out-of-range operands that R8 defines.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
    localparam int DIGIT_W   = 4;
    localparam int RADIX     = 10;
    localparam int CORR_AMT  = (1 << DIGIT_W) - RADIX;
    localparam int MAX_DIGIT = RADIX - 1;
    typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/bcd_ripple_add.sv
module bcd_ripple_add #(
    parameter int W = bcd_adder_pkg::DIGIT_W
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         c_in,
    output logic [W-1:0] total,
    output logic         c_out
);
    always_comb begin
        logic carry;
        carry = c_in;
        total = '0;
        for (int i = 0; i < W; i++) begin
            total[i] = op_x[i] ^ op_y[i] ^ carry;
            carry    = (op_x[i] & op_y[i]) | (op_x[i] & carry) | (op_y[i] & carry);
        end
        c_out = carry;
    end
endmodule

// File: rtl/bcd_range_detect.sv
module bcd_range_detect (
    input  bcd_adder_pkg::digit_t raw_sum,
    input  logic                  raw_carry,
    output logic                  need_fix
);
    // Raw result is out of decimal range when it overflowed 4 bits
    // or when the 4-bit value is 10..15 (top bit set with bit 2 or bit 1).
    always_comb begin
        need_fix = raw_carry | (raw_sum[3] & (raw_sum[2] | raw_sum[1]));
    end
endmodule

// File: rtl/bcd_fixup.sv
module bcd_fixup #(
    parameter int W = bcd_adder_pkg::DIGIT_W
) (
    input  logic [W-1:0] raw_sum,
    input  logic         need_fix,
    output logic [W-1:0] fixed_sum,
    output logic         fix_carry
);
    localparam logic [W-1:0] SIX  = W'(bcd_adder_pkg::CORR_AMT);
    localparam logic [W-1:0] NONE = '0;

    logic [W-1:0] addend;

    always_comb begin
        addend = need_fix ? SIX : NONE;
    end

    bcd_ripple_add #(.W(W)) u_fix_add (
        .op_x  (raw_sum),
        .op_y  (addend),
        .c_in  (1'b0),
        .total (fixed_sum),
        .c_out (fix_carry)
    );
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder (
    input  logic [3:0] a_digit,
    input  logic [3:0] b_digit,
    input  logic       carry_in,
    output logic [3:0] sum_digit,
    output logic       carry_out
);
    import bcd_adder_pkg::*;

    digit_t bin_sum;
    logic   bin_carry;
    logic   adjust;
    digit_t fixed_sum;
    logic   fix_carry;

    bcd_ripple_add #(.W(DIGIT_W)) u_bin_add (
        .op_x  (a_digit),
        .op_y  (b_digit),
        .c_in  (carry_in),
        .total (bin_sum),
        .c_out (bin_carry)
    );

    bcd_range_detect u_detect (
        .raw_sum   (bin_sum),
        .raw_carry (bin_carry),
        .need_fix  (adjust)
    );

    bcd_fixup #(.W(DIGIT_W)) u_fix (
        .raw_sum   (bin_sum),
        .need_fix  (adjust),
        .fixed_sum (fixed_sum),
        .fix_carry (fix_carry)
    );

    always_comb begin
        sum_digit = fixed_sum;
        carry_out = bin_carry | fix_carry;
    end
endmodule

// File: rtl/bcd_digit_adder_chk.sv
module bcd_digit_adder_chk (
    input logic [3:0] a_digit,
    input logic [3:0] b_digit,
    input logic       carry_in,
    input logic [3:0] sum_digit,
    input logic       carry_out,
    input logic [3:0] bin_sum,
    input logic       bin_carry,
    input logic       adjust
);
    logic [4:0] tot;
    logic       valid_ops;
    logic       known;

    always_comb begin
        tot       = {1'b0, a_digit} + {1'b0, b_digit} + {4'b0, carry_in};
        valid_ops = (a_digit <= 4'd9) && (b_digit <= 4'd9);
        known     = !$isunknown({a_digit, b_digit, carry_in, sum_digit,
                                 carry_out, bin_sum, bin_carry, adjust});
        if (known) begin
            // R1: an in-range binary result passes through unchanged
            a_r1_pass_through: assert (({bin_carry, bin_sum} > 5'd9) ||
                                        (sum_digit == bin_sum && !carry_out))
                else $error("a_r1_pass_through");
            // R2: totals of ten or more must raise the decimal carry
            a_r2_carry_on_ten: assert ((tot < 5'd10) || carry_out)
                else $error("a_r2_carry_on_ten");
            // R3: a binary overflow always yields a decimal carry
            a_r3_overflow_carry: assert (!bin_carry || carry_out)
                else $error("a_r3_overflow_carry");
            // R7: for digit operands the result encodes the decimal total
            a_r7_decimal_value: assert (!valid_ops ||
                                 ({1'b0, sum_digit} + (carry_out ? 5'd10 : 5'd0) == tot))
                else $error("a_r7_decimal_value");
            // R8: for digit operands the result digit stays a digit
            a_r8_digit_range: assert (!valid_ops || sum_digit <= 4'd9)
                else $error("a_r8_digit_range");
        end
    end
endmodule

bind bcd_digit_adder bcd_digit_adder_chk u_chk (
    .a_digit   (a_digit),
    .b_digit   (b_digit),
    .carry_in  (carry_in),
    .sum_digit (sum_digit),
    .carry_out (carry_out),
    .bin_sum   (bin_sum),
    .bin_carry (bin_carry),
    .adjust    (adjust)
);

// File: tb/test_bcd_digit_adder.sv
module test_bcd_digit_adder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_digit = 4'd0;
    logic [3:0] b_digit = 4'd0;
    logic       carry_in = 1'b0;
    logic [3:0] sum_digit;
    logic       carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcd_digit_adder i_bcd_digit_adder (
        .a_digit   (a_digit),
        .b_digit   (b_digit),
        .carry_in  (carry_in),
        .sum_digit (sum_digit),
        .carry_out (carry_out)
    );

    task automatic check(input string req, input logic [3:0] exp_d, input logic exp_c);
        checks++;
        if (sum_digit !== exp_d || carry_out !== exp_c) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d cin=%0d actual digit=%0d carry=%0d expected digit=%0d carry=%0d",
                     req, a_digit, b_digit, carry_in, sum_digit, carry_out, exp_d, exp_c);
        end
    endtask

    task automatic apply(input int a, input int b, input int c, input string req);
        int t;
        logic [3:0] ed;
        logic       ec;
        @(posedge clk);
        #1;
        a_digit  = 4'(a);
        b_digit  = 4'(b);
        carry_in = 1'(c);
        t = a + b + c;
        if (t >= 10) begin
            ed = 4'((t + 6) % 16);
            ec = 1'b1;
        end else begin
            ed = 4'(t);
            ec = 1'b0;
        end
        @(negedge clk);
        check(req, ed, ec);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string req;
        int t;
        repeat (2) @(negedge clk);
        check("R1 reset state", 4'd0, 1'b0);
        rst = 1'b0;
        apply(2, 6, 0, "R4");
        apply(8, 9, 0, "R5");
        apply(6, 5, 0, "R6");
        apply(9, 9, 1, "R3 R7 max digit total");
        apply(9, 0, 0, "R1 boundary nine");
        apply(9, 1, 0, "R2 boundary ten");
        apply(15, 15, 1, "R8 largest operands");
        apply(12, 0, 0, "R8 operand above nine");
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    t = a + b + c;
                    if (a > 9 || b > 9) req = "R8 out-of-range operand";
                    else if (t <= 9)    req = (c == 1) ? "R1 R7 small total" : "R1 small total";
                    else if (t <= 15)   req = (c == 1) ? "R2 R7 mid total" : "R2 mid total";
                    else                req = (c == 1) ? "R3 R7 binary overflow" : "R3 binary overflow";
                    apply(a, b, c, req);
                end
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule